// File: doc/BRIEF.md
# Strobe-Driven FIFO with Rewind and Half-Level Flag

This block is a first-in/first-out word buffer, nine bits wide, whose depth is a parameter (a power of two, 2048 by default). A producer stores words by pulsing an active-low write strobe. A consumer takes words out by pulsing an active-low read strobe. Neither strobe is tied to the system clock. Both are brought into the clock domain through two flip-flops, and the block acts on the edges it sees in the synchronised copies. All nine bits are user data; the ninth is commonly used for parity or a marker and is never interpreted.

Three active-low flags report the fill state. Empty, Full and Half-Full each change on a particular strobe edge. A flag that announces less room or less data changes on the falling edge. A flag that announces more room or more data changes on the rising edge, once the transfer is finished. An active-low rewind input moves the read position back to the first word written since reset, so a consumer can replay a frame. The output is a data bus plus an enable that stands in for a three-state driver.

A write reserves its slot on the falling edge of the strobe. The data is captured on the rising edge, so the data input must be held stable until then and for two clocks after. A read drives its word and raises the enable on the falling edge. It releases its slot on the rising edge.

Top module: `strobe_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following edge shows `empty_n`=0, `full_n`=1, `half_n`=1 and `dout_oe`=0, and the buffer holds no words.
- R2: Words leave in the order they were stored, with all nine bits intact, for every fill level from 1 to DEPTH.
- R3: An accepted write lowers `full_n` on the falling edge of its strobe when that write takes the last free slot. Its data is stored on the rising edge.
- R4: `empty_n` goes low on the falling edge of a read strobe that removes the only remaining word. It goes high on the rising edge of a write strobe that stores a word into an empty buffer.
- R5: `full_n` returns high on the rising edge of a read strobe taken from a full buffer.
- R6: `half_n` goes low on the falling edge of a write that brings the occupancy above DEPTH/2. It returns high on the rising edge of a read that brings the occupancy to DEPTH/2 or less. Whenever `full_n` is low, `half_n` is low.
- R7: `dout_oe` is high only from the falling edge to the rising edge of an accepted read. During that time `dout` is stable and carries the oldest word.
- R8: A write strobe while the buffer is full is ignored: no word is stored and the flags do not change. `empty_n` and `full_n` are never low together.
- R9: A read strobe while the buffer is empty is ignored: `dout_oe` stays low, `empty_n` stays low and no word is consumed.
- R10: A low pulse on `rtx_n` returns the read position to the first word stored since reset. The write position is left as it is. All three flags are re-derived from the resulting occupancy, which is the number of words stored since reset. This holds while that number is at most DEPTH.
- R11: A rewind that arrives while an accepted read strobe is low waits until that strobe has gone high. The word being read stays on `dout` until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous master reset, active low |
| wr_n | input | 1 | Write strobe, active low, asynchronous to clk |
| rd_n | input | 1 | Read strobe, active low, asynchronous to clk |
| rtx_n | input | 1 | Rewind request, active low pulse |
| din | input | 9 | Word to store, held stable across the write strobe's rising edge |
| dout | output | 9 | Word being read |
| dout_oe | output | 1 | High while `dout` would be driven onto the bus |
| empty_n | output | 1 | Empty flag, active low |
| full_n | output | 1 | Full flag, active low |
| half_n | output | 1 | Above-half flag, active low |

## Verification
The bench builds the buffer with DEPTH=8, so the half-level threshold sits at four words and the full point at eight. This makes it practical to sweep every fill level from one word to full, then drain each one while comparing every word and every flag edge. The small depth also lets the bench reach the overflow attempt, the underflow attempt and a rewind across a partly drained buffer in a few hundred strobes. It also covers a rewind held back by an open read.

// File: rtl/sfifo_pkg.sv
// Package: shared width and the event record produced by the strobe synchronisers.
// Assumes: every user of the buffer agrees on the nine-bit word.
package sfifo_pkg;
    localparam int WORD_W = 9;
    typedef logic [WORD_W-1:0] word_t;

    // Edge events of one synchronised strobe, each valid for one clock.
    typedef struct packed {
        logic fall;
        logic rise;
    } strobe_ev_t;
endpackage

// File: rtl/sfifo_edge_sync.sv
// Module: brings one active-low strobe into the clock domain through two
// flip-flops and reports its falling and rising edges as one-clock events.
// Assumes: the strobe stays at each level for at least two clocks; idle level is high.
module sfifo_edge_sync
    import sfifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe_n,
    output strobe_ev_t ev
);
    logic meta_q, sync_q, prev_q;

    // Two-stage synchroniser plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            sync_q <= 1'b1;
            prev_q <= 1'b1;
        end else begin
            meta_q <= strobe_n;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    // Edge events from the registered copies.
    always_comb begin
        ev.fall = prev_q & ~sync_q;
        ev.rise = ~prev_q & sync_q;
    end
endmodule

// File: rtl/sfifo_store.sv
// Module: word storage, one write port and one asynchronous read port.
// Assumes: the controller never writes the slot that it is reading.
module sfifo_store
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);
    word_t mem [DEPTH];

    // Store a word when the controller commits a write.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sfifo_ctrl.sv
// Module: pointers, the two occupancy counters and the flags.
// Room is counted by `fill`: up on a write fall, down on a read rise.
// Data is counted by `avail`: up on a write rise, down on a read fall.
// Full and half come from `fill`, empty from `avail`. A rewind reloads both
// counters from the saturating count of words stored since reset.
// Assumes: DEPTH is a power of two, at least 4.
module sfifo_ctrl
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  strobe_ev_t    wr_ev,
    input  strobe_ev_t    rd_ev,
    input  strobe_ev_t    rtx_ev,
    input  word_t         rdata,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output word_t         dout,
    output logic          dout_oe,
    output logic          empty_n,
    output logic          full_n,
    output logic          half_n
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

    logic [AW-1:0] wptr_q, rptr_q, rptr_n;
    logic [CW-1:0] fill_q, fill_n, avail_q, avail_n, stored_q, stored_n, rew_sum;
    logic          wr_res_q, wr_res_n, rd_act_q, rd_act_n, pend_q, pend_n;
    logic          wr_start, wr_done, rd_start, rd_done, rew_req, do_rew;

    // Next-state logic for counters, pointers and the rewind request.
    always_comb begin
        wr_start = wr_ev.fall & ~wr_res_q & (fill_q != FULL_CNT);
        wr_done  = wr_ev.rise & wr_res_q;
        rd_start = rd_ev.fall & ~rd_act_q & (avail_q != '0);
        rd_done  = rd_ev.rise & rd_act_q;

        wr_res_n = wr_start | (wr_res_q & ~wr_done);
        rd_act_n = rd_start | (rd_act_q & ~rd_done);
        stored_n = (wr_done && stored_q != FULL_CNT) ? stored_q + 1'b1 : stored_q;

        fill_n  = fill_q + CW'(wr_start) - CW'(rd_done);
        avail_n = avail_q + CW'(wr_done) - CW'(rd_start);
        rptr_n  = rd_start ? rptr_q + 1'b1 : rptr_q;

        rew_req = rtx_ev.fall | pend_q;
        do_rew  = rew_req & ~rd_act_n;
        pend_n  = rew_req & ~do_rew;
        rew_sum = stored_n + CW'(wr_res_n);
        if (do_rew) begin
            rptr_n  = '0;
            avail_n = stored_n;
            fill_n  = (rew_sum > FULL_CNT) ? FULL_CNT : rew_sum;
        end
    end

    // State and registered flags, all updated on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q   <= '0;
            rptr_q   <= '0;
            fill_q   <= '0;
            avail_q  <= '0;
            stored_q <= '0;
            wr_res_q <= 1'b0;
            rd_act_q <= 1'b0;
            pend_q   <= 1'b0;
            dout     <= '0;
            dout_oe  <= 1'b0;
            empty_n  <= 1'b0;
            full_n   <= 1'b1;
            half_n   <= 1'b1;
        end else begin
            wptr_q   <= wr_done ? wptr_q + 1'b1 : wptr_q;
            rptr_q   <= rptr_n;
            fill_q   <= fill_n;
            avail_q  <= avail_n;
            stored_q <= stored_n;
            wr_res_q <= wr_res_n;
            rd_act_q <= rd_act_n;
            pend_q   <= pend_n;
            if (rd_start) dout <= rdata;
            dout_oe  <= rd_act_n;
            empty_n  <= (avail_n != '0);
            full_n   <= (fill_n != FULL_CNT);
            half_n   <= !(fill_n > HALF_CNT);
        end
    end

    assign we    = wr_done;
    assign waddr = wptr_q;
    assign raddr = rptr_q;
endmodule

// File: rtl/strobe_fifo.sv
// Module: top level; synchronises the three strobes, then joins the controller
// to the word storage.
// Assumes: din is held stable from the write strobe's rising edge for two clocks.
module strobe_fifo
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_n,
    input  logic       rd_n,
    input  logic       rtx_n,
    input  logic [8:0] din,
    output logic [8:0] dout,
    output logic       dout_oe,
    output logic       empty_n,
    output logic       full_n,
    output logic       half_n
);
    localparam int NSTROBE = 3;

    logic [NSTROBE-1:0] raw_n;
    strobe_ev_t         ev [NSTROBE];
    logic               we;
    logic [AW-1:0]      waddr, raddr;
    word_t              rdata;

    assign raw_n = {rtx_n, rd_n, wr_n};

    // One synchroniser per strobe.
    for (genvar g = 0; g < NSTROBE; g++) begin : g_sync
        sfifo_edge_sync u_sync (
            .clk(clk), .rst_n(rst_n), .strobe_n(raw_n[g]), .ev(ev[g])
        );
    end

    sfifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_ev(ev[0]), .rd_ev(ev[1]), .rtx_ev(ev[2]),
        .rdata(rdata), .we(we), .waddr(waddr), .raddr(raddr),
        .dout(dout), .dout_oe(dout_oe),
        .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
    );

    sfifo_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .we(we), .waddr(waddr), .wdata(din),
        .raddr(raddr), .rdata(rdata)
    );
endmodule

// File: rtl/strobe_fifo_chk.sv
// Module: port-level properties of strobe_fifo, attached by bind.
// Assumes: rst_n is low at the first clock edge.
module strobe_fifo_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [8:0] dout,
    input logic       dout_oe,
    input logic       empty_n,
    input logic       full_n,
    input logic       half_n
);
    assert_reset_flags_R1: assert property (@(posedge clk)
        !rst_n |=> (!empty_n && full_n && half_n && !dout_oe));

    assert_full_implies_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !full_n |-> !half_n);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(!empty_n && !full_n));

    assert_dout_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && $past(dout_oe)) |-> $stable(dout));

    assert_empty_on_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(empty_n) |-> dout_oe);

    assert_full_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full_n) |-> ($past(dout_oe) && !dout_oe));
endmodule

bind strobe_fifo strobe_fifo_chk u_chk (
    .clk(clk), .rst_n(rst_n), .dout(dout), .dout_oe(dout_oe),
    .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
);

// File: tb/strobe_fifo_tb.sv
module strobe_fifo_tb;
    localparam int D = 8;
    localparam int SETTLE = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_n = 1'b1, rd_n = 1'b1, rtx_n = 1'b1;
    logic [8:0] din = '0;
    logic [8:0] dout;
    logic       dout_oe, empty_n, full_n, half_n;

    int total = 0, bad = 0;
    int wc = 0, rc = 0;
    logic [8:0] hist [64];
    bit done = 0;

    always #2 clk = ~clk;

    strobe_fifo #(.DEPTH(D)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rtx_n(rtx_n),
        .din(din), .dout(dout), .dout_oe(dout_oe),
        .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 empty_n", empty_n, 0);
        chk("R1 full_n", full_n, 1);
        chk("R1 half_n", half_n, 1);
        chk("R1 dout_oe", dout_oe, 0);
        rst_n = 1'b1;
        wc = 0;
        rc = 0;
        settle();
    endtask

    task automatic wr_op(input logic [8:0] d);
        int occ = wc - rc;
        bit ok = (occ < D);
        din = d;
        wr_n = 1'b0;
        settle();
        if (ok) begin
            chk("R3 full_n at write fall", full_n, (occ + 1 != D));
            chk("R6 half_n at write fall", half_n, !((occ + 1) > D / 2));
            chk("R4 empty_n held until write rise", empty_n, (occ != 0));
        end else begin
            chk("R8 full_n on ignored write", full_n, 0);
        end
        wr_n = 1'b1;
        settle();
        if (ok) begin
            hist[wc] = d;
            wc++;
            chk("R4 empty_n at write rise", empty_n, 1);
        end
    endtask

    task automatic rd_op();
        int occ = wc - rc;
        bit ok = (occ > 0);
        rd_n = 1'b0;
        settle();
        if (ok) begin
            chk("R7 dout_oe during read", dout_oe, 1);
            chk("R2 dout word", dout, hist[rc]);
            chk("R4 empty_n at read fall", empty_n, (occ - 1 != 0));
            chk("R5 full_n held until read rise", full_n, (occ != D));
        end else begin
            chk("R9 dout_oe on ignored read", dout_oe, 0);
            chk("R9 empty_n on ignored read", empty_n, 0);
        end
        rd_n = 1'b1;
        settle();
        if (ok) rc++;
        chk("R5 full_n after read rise", full_n, 1);
        chk("R6 half_n after read rise", half_n, !((wc - rc) > D / 2));
        chk("R7 dout_oe after read rise", dout_oe, 0);
    endtask

    task automatic rtx_pulse();
        rtx_n = 1'b0;
        settle();
        rtx_n = 1'b1;
        settle();
    endtask

    task automatic chk_flags(input string tag);
        chk({tag, " empty_n"}, empty_n, (wc - rc) != 0);
        chk({tag, " full_n"}, full_n, (wc - rc) != D);
        chk({tag, " half_n"}, half_n, !((wc - rc) > D / 2));
    endtask

    initial begin
        do_reset();
        rd_op();                       // R9: read on empty

        // R2/R3/R4/R6: every fill level, then drain
        for (int k = 1; k <= D; k++) begin
            do_reset();
            for (int i = 0; i < k; i++)
                wr_op(9'((k * 73 + i * 29) ^ ((i % 2) != 0 ? 9'h100 : 9'h000)));
            for (int i = 0; i < k; i++) rd_op();
            rd_op();
        end

        // R8: a write into a full buffer is lost
        do_reset();
        for (int i = 0; i <= D; i++) wr_op(9'(9'h0A5 + i * 3));
        chk("R8 words kept", wc, D);
        for (int i = 0; i < D; i++) rd_op();
        chk_flags("R8 drained");

        // R10: rewind after a partial drain
        do_reset();
        for (int i = 0; i < 5; i++) wr_op(9'(9'h1F0 - i * 7));
        for (int i = 0; i < 3; i++) rd_op();
        rtx_pulse();
        rc = 0;
        chk_flags("R10 after rewind");
        for (int i = 0; i < 5; i++) rd_op();
        chk_flags("R10 drained");

        // R11: rewind during an open read is held back
        do_reset();
        for (int i = 0; i < 6; i++) wr_op(9'(9'h033 + i * 41));
        rd_op();
        rd_n = 1'b0;
        settle();
        chk("R11 word before rewind", dout, hist[1]);
        rtx_pulse();
        chk("R11 dout_oe held", dout_oe, 1);
        chk("R11 word kept", dout, hist[1]);
        rd_n = 1'b1;
        settle();
        rc = 0;
        chk_flags("R11 after deferred rewind");
        for (int i = 0; i < 6; i++) rd_op();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule